// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner

This block drives a common-cathode LED panel one digit at a time. A free-running scan walks the active grids in turn. Each grid owns a slot of sixteen subslots, and a subslot advances on each pulse of a scan clock enable. While a grid is selected, the block reads the two display-memory bytes that belong to that digit through a combinational read port. It drives the matching segment pattern for an on-time fraction set by a 3-bit brightness code, then blanks the segments for the rest of the slot.

Two panel shapes are supported: seven grids with eleven segments, or six grids with twelve segments. One output pin serves as the seventh grid in the first shape and as the twelfth segment in the second. A level input turns the display on or off; scanning continues while the display is off. A change of panel shape blanks the panel until a display-control write arrives with the display-on flag set. The block pulses a strobe once per complete scan so that a neighbouring key scanner can latch its inputs.

Top module: `ledscan_top`

## Requirements
- R1: During and after an active-low reset, the scan stands at grid 1, subslot 0. The read address is 0, the shape register holds the seven-grid shape, and every segment and grid output is low.
- R2: The subslot index advances only on a cycle with `tick` high. After subslot 15 it returns to 0 and the next grid (in order 1, 2, ...) is selected.
- R3: At most one grid is active at a time (the shared pin counts as grid 7 in the seven-grid shape). No grid is active during subslot 0 of any slot, so every grid change has a blank subslot.
- R4: Segments are lit only in subslots 1 through N. N is 1, 2, 4, 10, 11, 12, 13 or 14 for brightness codes 0 through 7.
- R5: For the digit at grid n, `rd_addr` is 2(n-1). `rd_even` bits 7:0 drive segments 8:1 (`seg_o[7:0]`). `rd_odd` bits 2:0 drive segments 11:9 (`seg_o[10:8]`). `rd_odd` bits 7:4 have no effect on any output.
- R6: With `mode_7g`=1 the scan covers 7 grids and `share_o` is grid 7. With `mode_7g`=0 it covers 6 grids and `share_o` is segment 12, taken from `rd_odd` bit 3.
- R7: `cycle_end` is high for exactly the one cycle in which a tick ends subslot 15 of the last grid. On the next cycle the scan is at grid 1, subslot 0.
- R8: With `disp_on`=0, all segment, grid and shared outputs are low, while the scan and `cycle_end` keep running.
- R9: When `mode_7g` differs from the stored shape, the outputs go low in that same cycle and the scan restarts at grid 1, subslot 0. The outputs stay blank until a cycle with `ctl_wr`=1 and `disp_on`=1. Presenting the stored shape again has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Scan clock enable, one subslot per pulse |
| mode_7g | input | 1 | Panel shape: 1 = 7 grids/11 segments, 0 = 6 grids/12 segments |
| disp_on | input | 1 | Display enable level |
| ctl_wr | input | 1 | Pulse: a display-control write was received |
| dim_code | input | 3 | Brightness code |
| rd_addr | output | 4 | Display memory address of the even byte of the current digit |
| rd_even | input | 8 | Memory byte at `rd_addr` |
| rd_odd | input | 8 | Memory byte at `rd_addr`+1 |
| seg_o | output | 11 | Segments 1 to 11, active high |
| grid_o | output | 6 | Grids 1 to 6, active high |
| share_o | output | 1 | Grid 7 or segment 12, depending on shape |
| cycle_end | output | 1 | One-cycle end-of-scan strobe |

## Verification
The hardest situation to reach from the ports is a shape change in the middle of a slot, followed by the blank interval and its release. The stimulus flips `mode_7g` part-way through a grid with the display on and holds `disp_on` high without a control write for longer than a full scan. It then issues `ctl_wr` and lets the six-grid shape run while the unused upper bits of the odd bytes are scrambled. A behavioural model in the bench follows the scan position through sparse and dense tick patterns and predicts every output on every cycle.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
  localparam int unsigned SUBSLOTS = 16;

  // On-time in subslots for each brightness code.
  function automatic int dim_on_count(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 10;
      3'd4:    return 11;
      3'd5:    return 12;
      3'd6:    return 13;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/ledscan_ctr.sv
module ledscan_ctr #(
  parameter int unsigned SUB_N  = 16,
  parameter int unsigned GRID_N = 7,
  localparam int unsigned SW = $clog2(SUB_N),
  localparam int unsigned GW = $clog2(GRID_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [GW-1:0] last_idx,
  output logic [GW-1:0] grid_idx,
  output logic [SW-1:0] sub_idx,
  output logic          frame_wrap
);
  logic [SW-1:0] sub_q;
  logic [GW-1:0] grid_q;
  logic          slot_end;

  assign slot_end   = tick && !restart && (sub_q == SW'(SUB_N - 1));
  assign frame_wrap = slot_end && (grid_q == last_idx);
  assign grid_idx   = grid_q;
  assign sub_idx    = sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      grid_q <= '0;
    end else if (restart) begin
      sub_q  <= '0;
      grid_q <= '0;
    end else if (tick) begin
      if (slot_end) begin
        sub_q  <= '0;
        grid_q <= (grid_q == last_idx) ? '0 : grid_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R2: no tick, no restart -> position frozen
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> ($stable(sub_q) && $stable(grid_q)));
  // R7: scan returns to the first grid after the strobe
  a_r7_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (grid_q == '0 && sub_q == '0));
  // R2: grid index never passes the last active grid
  a_r2_grid_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    restart || (grid_q <= last_idx));
endmodule

// File: rtl/ledscan_mode.sv
module ledscan_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_7g,
  input  logic disp_on,
  input  logic ctl_wr,
  output logic mode_q,
  output logic mode_chg,
  output logic lit_en
);
  logic blank_q;

  assign mode_chg = (mode_7g != mode_q);
  assign lit_en   = disp_on && !blank_q && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b1;
      blank_q <= 1'b0;
    end else if (mode_chg) begin
      mode_q  <= mode_7g;
      blank_q <= 1'b1;
    end else if (ctl_wr && disp_on) begin
      blank_q <= 1'b0;
    end
  end

  // R9: a shape change keeps the panel dark on the following cycle
  a_r9_dark_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !lit_en);
  // R9: only a control write with display on ends the blank interval
  a_r9_release_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!lit_en && !ctl_wr && !mode_chg && disp_on) |=> !lit_en);
endmodule

// File: rtl/ledscan_drive.sv
module ledscan_drive #(
  parameter int unsigned SUB_N  = 16,
  parameter int unsigned GRID_N = 7,
  parameter int unsigned SEG_N  = 11,
  localparam int unsigned SW = $clog2(SUB_N),
  localparam int unsigned GW = $clog2(GRID_N),
  localparam int unsigned ODD_USED = SEG_N - 8
) (
  input  logic              lit_en,
  input  logic              mode_q,
  input  logic [GW-1:0]     grid_idx,
  input  logic [SW-1:0]     sub_idx,
  input  logic [2:0]        dim_code,
  input  logic [7:0]        rd_even,
  input  logic [7:0]        rd_odd,
  output logic [SEG_N-1:0]  seg_o,
  output logic [GRID_N-2:0] grid_o,
  output logic              share_o,
  output logic              grid_on,
  output logic              seg_on
);
  import ledscan_pkg::*;

  assign grid_on = lit_en && (sub_idx != '0);
  assign seg_on  = grid_on && (int'(sub_idx) <= dim_on_count(dim_code));
  assign seg_o   = seg_on ? {rd_odd[ODD_USED-1:0], rd_even} : '0;

  for (genvar gi = 0; gi < GRID_N - 1; gi++) begin : g_grid
    assign grid_o[gi] = grid_on && (grid_idx == GW'(gi));
  end

  assign share_o = mode_q ? (grid_on && (grid_idx == GW'(GRID_N - 1)))
                          : (seg_on && rd_odd[ODD_USED]);
endmodule

// File: rtl/ledscan_top.sv
module ledscan_top #(
  parameter int unsigned GRID_N = 7,
  parameter int unsigned SEG_N  = 11,
  localparam int unsigned SUB_N = ledscan_pkg::SUBSLOTS,
  localparam int unsigned SW = $clog2(SUB_N),
  localparam int unsigned GW = $clog2(GRID_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_7g,
  input  logic              disp_on,
  input  logic              ctl_wr,
  input  logic [2:0]        dim_code,
  output logic [GW:0]       rd_addr,
  input  logic [7:0]        rd_even,
  input  logic [7:0]        rd_odd,
  output logic [SEG_N-1:0]  seg_o,
  output logic [GRID_N-2:0] grid_o,
  output logic              share_o,
  output logic              cycle_end
);
  import ledscan_pkg::*;

  logic          mode_q, mode_chg, lit_en, grid_on, seg_on;
  logic [GW-1:0] grid_idx, last_idx;
  logic [SW-1:0] sub_idx;

  assign last_idx = mode_q ? GW'(GRID_N - 1) : GW'(GRID_N - 2);
  assign rd_addr  = {grid_idx, 1'b0};

  ledscan_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_7g(mode_7g), .disp_on(disp_on),
    .ctl_wr(ctl_wr), .mode_q(mode_q), .mode_chg(mode_chg), .lit_en(lit_en)
  );

  ledscan_ctr #(.SUB_N(SUB_N), .GRID_N(GRID_N)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(mode_chg),
    .last_idx(last_idx), .grid_idx(grid_idx), .sub_idx(sub_idx),
    .frame_wrap(cycle_end)
  );

  ledscan_drive #(.SUB_N(SUB_N), .GRID_N(GRID_N), .SEG_N(SEG_N)) u_drv (
    .lit_en(lit_en), .mode_q(mode_q), .grid_idx(grid_idx), .sub_idx(sub_idx),
    .dim_code(dim_code), .rd_even(rd_even), .rd_odd(rd_odd), .seg_o(seg_o),
    .grid_o(grid_o), .share_o(share_o), .grid_on(grid_on), .seg_on(seg_on)
  );

  // R3: grids never overlap, shared pin counted when it is a grid
  a_r3_one_grid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_q && share_o, grid_o}));
  // R3: guard subslot carries no grid
  a_r3_guard_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_idx == '0) |-> (grid_o == '0 && !(mode_q && share_o)));
  // R8: display off darkens every driven pin
  a_r8_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (seg_o == '0 && grid_o == '0 && !share_o));
  // R4: lit segments only inside the on-time window
  a_r4_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_o != '0) |-> (int'(sub_idx) <= dim_on_count(dim_code)));
  // R6: six-grid shape never drives a seventh grid
  a_r6_six_grids: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !mode_chg) |-> (grid_idx <= GW'(GRID_N - 2)));
endmodule

// File: tb/sim_ledscan_top.sv
module sim_ledscan_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        mode_7g = 1'b1;
  logic        disp_on = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [2:0]  dim_code = 3'd0;
  logic [3:0]  rd_addr;
  logic [7:0]  rd_even, rd_odd;
  logic [10:0] seg_o;
  logic [5:0]  grid_o;
  logic        share_o, cycle_end;
  logic [7:0]  mem [0:15];

  int checks = 0;
  int errors = 0;
  int mg, ms, mblank, mmode;
  int ends_seen, lit_seen;
  bit done = 0;

  always #2 clk = ~clk;

  assign rd_even = mem[rd_addr];
  assign rd_odd  = mem[rd_addr + 4'd1];

  ledscan_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_7g(mode_7g),
    .disp_on(disp_on), .ctl_wr(ctl_wr), .dim_code(dim_code),
    .rd_addr(rd_addr), .rd_even(rd_even), .rd_odd(rd_odd),
    .seg_o(seg_o), .grid_o(grid_o), .share_o(share_o), .cycle_end(cycle_end)
  );

  function automatic int on_time(input int code);
    int t[8] = '{1, 2, 4, 10, 11, 12, 13, 14};
    return t[code];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Advance the model with the inputs seen at the last edge, then compare.
  task automatic cyc();
    bit chg, act, gon, son;
    int eg, es, esh, ee;
    logic [7:0] ev, od;
    @(negedge clk);
    if (!rst_n) begin
      mg = 0; ms = 0; mblank = 0; mmode = 1;
    end else if (int'(mode_7g) != mmode) begin
      mmode = mode_7g; mblank = 1; mg = 0; ms = 0;
    end else begin
      if (ctl_wr && disp_on) mblank = 0;
      if (tick) begin
        if (ms == 15) begin
          ms = 0;
          mg = (mg == (mmode ? 6 : 5)) ? 0 : mg + 1;
        end else ms++;
      end
    end
    chg = (int'(mode_7g) != mmode);
    act = disp_on && !mblank && !chg;
    gon = act && ms != 0;
    son = gon && ms <= on_time(dim_code);
    ev = mem[2 * mg];
    od = mem[2 * mg + 1];
    eg = (gon && mg < 6) ? (1 << mg) : 0;
    es = son ? {od[2:0], ev} : 0;
    esh = mmode ? int'(gon && mg == 6) : int'(son && od[3]);
    ee = int'(tick && !chg && ms == 15 && mg == (mmode ? 6 : 5));
    check("R5 rd_addr", rd_addr, 2 * mg);
    check("R3 grid_o", grid_o, eg);
    check("R4 seg_o", seg_o, es);
    check("R6 share_o", share_o, esh);
    check("R7 cycle_end", cycle_end, ee);
    if (cycle_end) ends_seen++;
    if (seg_o != 0 || grid_o != 0 || share_o) lit_seen++;
  endtask

  task automatic run(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      tick = (i % period == 0);
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++) mem[i] = 8'((i * 37 + seed * 11) ^ (seed << i % 5));
  endtask

  initial begin
    fill(1);
    for (int i = 0; i < 4; i++) cyc();
    // R1: reset state at the ports
    check("R1 rst seg", seg_o, 0);
    check("R1 rst grid", {grid_o, share_o}, 0);
    check("R1 rst addr", rd_addr, 0);
    rst_n = 1'b1;
    disp_on = 1'b1;
    dim_code = 3'd7;
    run(5, 1);
    // R1: seven-grid shape is stored after reset (no blank on display on)
    check("R1 no blank at start", lit_seen > 0, 1);
    run(230, 1);
    // R4: every brightness code, one full scan each
    for (int d = 0; d < 8; d++) begin
      dim_code = 3'(d);
      fill(d + 2);
      run(112, 1);
    end
    // R2: sparse ticks
    dim_code = 3'd3;
    run(400, 3);
    // R8: display off, scan keeps running
    disp_on = 1'b0;
    ends_seen = 0; lit_seen = 0;
    run(224, 1);
    check("R8 strobe while off", ends_seen, 2);
    check("R8 dark while off", lit_seen, 0);
    disp_on = 1'b1;
    run(40, 1);
    // R9: shape change mid-slot blanks until a control write
    mode_7g = 1'b0;
    lit_seen = 0;
    run(150, 1);
    check("R9 blank after change", lit_seen, 0);
    ctl_wr = 1'b1;
    cyc();
    ctl_wr = 1'b0;
    lit_seen = 0;
    // R5: upper odd bits scrambled, R6: six-grid shape
    for (int f = 0; f < 3; f++) begin
      fill(f + 20);
      for (int i = 1; i < 16; i += 2) mem[i][7:4] = 4'(f * 5 + i);
      run(96, 1);
    end
    check("R6 lit in six-grid shape", lit_seen > 0, 1);
    // R9: same shape again has no effect
    ctl_wr = 1'b1;
    cyc();
    ctl_wr = 1'b0;
    lit_seen = 0;
    run(96, 1);
    check("R9 same shape no blank", lit_seen > 0, 1);
    mode_7g = 1'b1;
    run(20, 1);
    ctl_wr = 1'b1;
    cyc();
    ctl_wr = 1'b0;
    run(224, 2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule